// File: doc/BRIEF.md
# Fast-Path Ethernet Frame Classifier

This block inspects a received Ethernet frame as it streams out of a packet buffer, one 32-bit word per valid cycle. It then picks one of three destinations for the frame. Streaming sample data goes to the DSP transmit chain. A device address-recovery frame rewrites the device IP address. Everything else goes to a processor-handled slow path. The frame is stored with two bytes of padding ahead of its Ethernet header, so each header field sits in a fixed 32-bit word. The classifier never parses headers. It probes those fixed words as they pass and keeps one sticky flag per probe.

A decision comes out once per frame, in the cycle after the end-of-frame word. It is a one-hot route select qualified by a one-cycle strobe. A recovery decision also loads the captured address into the IP register. A slow-path decision also reports a length for the processor. The data UDP port and the invalid-header value are inputs, so they can be changed between frames. A fast-path consumer starts reading at word 11, directly after the padded Ethernet, IPv4 and UDP headers.

Top module: `frame_route_classifier`

## Requirements
- R1: While reset is asserted and right after it is released, `route_valid` is 0, `route_sel` is 3'b000, `ip_addr` equals `IP_RESET` (default 0) and `slow_len` is 0.
- R2: A frame takes the fast path when both of these hold. Bits 15:0 of word 9 equal `cfg_data_port`. Word 11 differs from `cfg_bad_hdr`. The fast path is reported as `route_sel` = 3'b001. Words are numbered from 0 at the word carrying `in_sof`.
- R3: If word 11 equals `cfg_bad_hdr`, the frame is not fast-path, even when the port matches. It is classified by the other tests.
- R4: A frame is a recovery frame when all of these hold. Bits 15:0 of word 3 are 16'hBEEE. Word 4 is 32'h61646472 (ASCII "addr"). Word 5 is present. It is reported as `route_sel` = 3'b010, and in the same cycle `ip_addr` takes the value of word 5.
- R5: A frame that passes both the fast-path test and the recovery test is reported as fast-path (3'b001), and `ip_addr` is left unchanged.
- R6: A frame whose end-of-frame word comes before word 11 is never fast-path. It is still classified, in the cycle after its end-of-frame word.
- R7: Any other frame is reported as slow path, `route_sel` = 3'b100. In the same cycle `slow_len` becomes the index of the frame's last word minus 3, clamped at 0 for frames shorter than four words.
- R8: `route_valid` is high for exactly one cycle per completed frame: the cycle after the end-of-frame word is accepted. `route_sel` is one-hot while `route_valid` is high and 3'b000 otherwise. Back-to-back one-word frames give one strobe each.
- R9: `ip_addr` changes only in a cycle where `route_valid` is high with `route_sel` = 3'b010.
- R10: A valid word without `in_sof` arrives while no frame is open is ignored. It produces no strobe, even if it carries `in_eof`.
- R11: A word with `in_sof` always starts a new frame at word 0. Any frame still open is dropped without a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A frame word is present on `in_word` |
| in_sof | input | 1 | This word is word 0 of a frame |
| in_eof | input | 1 | This word is the last word of the frame |
| in_word | input | 32 | Frame word, bytes in network order, byte 0 in bits 31:24 |
| cfg_data_port | input | 16 | UDP port that marks streaming sample data |
| cfg_bad_hdr | input | 32 | Payload header value that disqualifies the fast path |
| route_valid | output | 1 | One-cycle strobe: a decision is on `route_sel` |
| route_sel | output | 3 | One-hot decision: bit 0 fast, bit 1 recovery, bit 2 slow |
| ip_addr | output | 32 | Device IP address register |
| slow_len | output | 12 | Length reported with the latest slow-path decision |

## Verification
Each probe keeps a sticky flag, and any fault in those flags shows at the ports in only one way: the wrong `route_sel` at the next strobe, one cycle after that frame's end-of-frame word. The bench therefore uses frames that pass exactly one test, frames that pass both, and frames that fall short of the probed words. If the word index slips by one, the probes read the wrong words, and `slow_len` is off on the very next slow-path decision. A missing or doubled strobe, or an IP register written outside a recovery decision, appears in the same cycle as the fault. The checks look at the cycle after every strobe as well as at the strobe itself.

// File: rtl/frc_pkg.sv
package frc_pkg;

   localparam int WORD_BITS  = 32;
   localparam int WORD_BYTES = WORD_BITS / 8;

   typedef enum logic [2:0] {
      ROUTE_NONE    = 3'b000,
      ROUTE_FAST    = 3'b001,
      ROUTE_RECOVER = 3'b010,
      ROUTE_SLOW    = 3'b100
   } route_e;

   // probe slots, in the order the sticky flags are kept
   localparam int PRB_ETYPE = 0;
   localparam int PRB_CODE  = 1;
   localparam int PRB_IP    = 2;
   localparam int PRB_PORT  = 3;
   localparam int PRB_HDR   = 4;
   localparam int NPROBE    = 5;

   // byte position of each probed field in the padded frame
   function automatic int probe_byte(input int slot, input int pad);
      case (slot)
         PRB_ETYPE: return pad + 12;      // last two header bytes: ethertype
         PRB_CODE:  return pad + 14;      // four code bytes after the header
         PRB_IP:    return pad + 18;      // address word after the code
         PRB_PORT:  return pad + 14 + 20; // UDP header, port in low half
         default:   return pad + 14 + 20 + 8; // first payload word
      endcase
   endfunction

   function automatic int probe_word(input int slot, input int pad);
      return probe_byte(slot, pad) / WORD_BYTES;
   endfunction

endpackage

// File: rtl/frc_word_tracker.sv
module frc_word_tracker #(
   parameter int IDX_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic             in_eof,
   output logic [IDX_W-1:0] cur_idx,
   output logic             take,
   output logic             last,
   output logic             frame_open
);
   localparam logic [IDX_W-1:0] IDX_MAX = '1;

   logic [IDX_W-1:0] next_idx;

   assign cur_idx = in_sof ? '0 : next_idx;
   assign take    = in_valid && (in_sof || frame_open);
   assign last    = take && in_eof;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         next_idx   <= '0;
         frame_open <= 1'b0;
      end else if (take) begin
         if (in_eof) begin
            next_idx   <= '0;
            frame_open <= 1'b0;
         end else begin
            next_idx   <= (cur_idx == IDX_MAX) ? cur_idx : cur_idx + 1'b1;
            frame_open <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/frc_field_probe.sv
module frc_field_probe
   import frc_pkg::*;
#(
   parameter int          IDX_W       = 12,
   parameter int          PAD_BYTES   = 2,
   parameter logic [15:0] RECOV_ETYPE = 16'hBEEE,
   parameter logic [31:0] RECOV_CODE  = 32'h61646472
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 take,
   input  logic                 in_sof,
   input  logic [IDX_W-1:0]     cur_idx,
   input  logic [WORD_BITS-1:0] in_word,
   input  logic [15:0]          cfg_data_port,
   input  logic [WORD_BITS-1:0] cfg_bad_hdr,
   output logic                 fast_hit,
   output logic                 recov_hit,
   output logic [WORD_BITS-1:0] recov_ip
);
   logic [NPROBE-1:0] field_ok;
   logic [NPROBE-1:0] hit_now;
   logic [NPROBE-1:0] seen_q;
   logic [NPROBE-1:0] seen_live;
   logic [WORD_BITS-1:0] ip_hold;

   always_comb begin
      field_ok            = '0;
      field_ok[PRB_ETYPE] = (in_word[15:0] == RECOV_ETYPE);
      field_ok[PRB_CODE]  = (in_word == RECOV_CODE);
      field_ok[PRB_IP]    = 1'b1;
      field_ok[PRB_PORT]  = (in_word[15:0] == cfg_data_port);
      field_ok[PRB_HDR]   = (in_word != cfg_bad_hdr);
   end

   for (genvar g = 0; g < NPROBE; g++) begin : g_probe
      localparam logic [IDX_W-1:0] AT = IDX_W'(probe_word(g, PAD_BYTES));

      assign hit_now[g]   = take && (cur_idx == AT) && field_ok[g];
      assign seen_live[g] = (in_sof ? 1'b0 : seen_q[g]) | hit_now[g];

      always_ff @(posedge clk) begin
         if (!rst_n)
            seen_q[g] <= 1'b0;
         else if (take)
            seen_q[g] <= seen_live[g];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ip_hold <= '0;
      else if (hit_now[PRB_IP])
         ip_hold <= in_word;
   end

   assign fast_hit  = seen_live[PRB_PORT] & seen_live[PRB_HDR];
   assign recov_hit = seen_live[PRB_ETYPE] & seen_live[PRB_CODE] & seen_live[PRB_IP];
   assign recov_ip  = hit_now[PRB_IP] ? in_word : ip_hold;
endmodule

// File: rtl/frc_route_decide.sv
module frc_route_decide
   import frc_pkg::*;
#(
   parameter int                   IDX_W        = 12,
   parameter int                   SLOW_BIAS    = 3,
   parameter bit                   LEN_SATURATE = 1'b1,
   parameter logic [WORD_BITS-1:0] IP_RESET     = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 last,
   input  logic [IDX_W-1:0]     cur_idx,
   input  logic                 fast_hit,
   input  logic                 recov_hit,
   input  logic [WORD_BITS-1:0] recov_ip,
   output logic                 route_valid,
   output logic [2:0]           route_sel,
   output logic [WORD_BITS-1:0] ip_addr,
   output logic [IDX_W-1:0]     slow_len
);
   localparam logic [IDX_W-1:0] BIAS = IDX_W'(SLOW_BIAS);

   logic [IDX_W-1:0] len_calc;
   route_e           pick;

   if (LEN_SATURATE) begin : g_len_clamp
      assign len_calc = (cur_idx < BIAS) ? '0 : cur_idx - BIAS;
   end else begin : g_len_wrap
      assign len_calc = cur_idx - BIAS;
   end

   always_comb begin
      if (fast_hit)
         pick = ROUTE_FAST;
      else if (recov_hit)
         pick = ROUTE_RECOVER;
      else
         pick = ROUTE_SLOW;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         route_valid <= 1'b0;
         route_sel   <= ROUTE_NONE;
         ip_addr     <= IP_RESET;
         slow_len    <= '0;
      end else begin
         route_valid <= last;
         route_sel   <= last ? pick : ROUTE_NONE;
         if (last && pick == ROUTE_RECOVER)
            ip_addr <= recov_ip;
         if (last && pick == ROUTE_SLOW)
            slow_len <= len_calc;
      end
   end
endmodule

// File: rtl/frame_route_classifier.sv
module frame_route_classifier
   import frc_pkg::*;
#(
   parameter int          IDX_W        = 12,
   parameter int          PAD_BYTES    = 2,
   parameter int          SLOW_BIAS    = 3,
   parameter bit          LEN_SATURATE = 1'b1,
   parameter logic [15:0] RECOV_ETYPE  = 16'hBEEE,
   parameter logic [31:0] RECOV_CODE   = 32'h61646472,
   parameter logic [31:0] IP_RESET     = 32'h0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic             in_eof,
   input  logic [31:0]      in_word,
   input  logic [15:0]      cfg_data_port,
   input  logic [31:0]      cfg_bad_hdr,
   output logic             route_valid,
   output logic [2:0]       route_sel,
   output logic [31:0]      ip_addr,
   output logic [IDX_W-1:0] slow_len
);
   localparam int LAST_PROBE = probe_word(PRB_HDR, PAD_BYTES);

   if (WORD_BITS != 32) begin : g_chk_word
      $error("classifier expects 32-bit words");
   end
   if (PAD_BYTES % WORD_BYTES != 2) begin : g_chk_pad
      $error("padding must leave the ethertype in the low half of a word");
   end
   if ((1 << IDX_W) <= LAST_PROBE + 1) begin : g_chk_idx
      $error("IDX_W too small to reach the payload word");
   end
   if (SLOW_BIAS < 0 || SLOW_BIAS >= (1 << IDX_W)) begin : g_chk_bias
      $error("SLOW_BIAS out of range");
   end

   logic [IDX_W-1:0] cur_idx_w;
   logic             take_w;
   logic             last_w;
   logic             frame_open_w;
   logic             fast_hit_w;
   logic             recov_hit_w;
   logic [31:0]      recov_ip_w;

   frc_word_tracker #(.IDX_W(IDX_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_sof     (in_sof),
      .in_eof     (in_eof),
      .cur_idx    (cur_idx_w),
      .take       (take_w),
      .last       (last_w),
      .frame_open (frame_open_w)
   );

   frc_field_probe #(
      .IDX_W       (IDX_W),
      .PAD_BYTES   (PAD_BYTES),
      .RECOV_ETYPE (RECOV_ETYPE),
      .RECOV_CODE  (RECOV_CODE)
   ) u_probe (
      .clk           (clk),
      .rst_n         (rst_n),
      .take          (take_w),
      .in_sof        (in_sof),
      .cur_idx       (cur_idx_w),
      .in_word       (in_word),
      .cfg_data_port (cfg_data_port),
      .cfg_bad_hdr   (cfg_bad_hdr),
      .fast_hit      (fast_hit_w),
      .recov_hit     (recov_hit_w),
      .recov_ip      (recov_ip_w)
   );

   frc_route_decide #(
      .IDX_W        (IDX_W),
      .SLOW_BIAS    (SLOW_BIAS),
      .LEN_SATURATE (LEN_SATURATE),
      .IP_RESET     (IP_RESET)
   ) u_decide (
      .clk         (clk),
      .rst_n       (rst_n),
      .last        (last_w),
      .cur_idx     (cur_idx_w),
      .fast_hit    (fast_hit_w),
      .recov_hit   (recov_hit_w),
      .recov_ip    (recov_ip_w),
      .route_valid (route_valid),
      .route_sel   (route_sel),
      .ip_addr     (ip_addr),
      .slow_len    (slow_len)
   );
endmodule

// File: rtl/frc_checker.sv
module frc_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic        in_sof,
   input logic        in_eof,
   input logic        frame_open,
   input logic        route_valid,
   input logic [2:0]  route_sel,
   input logic [31:0] ip_addr
);
   assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      route_valid |-> ($countones(route_sel) == 1));

   assert_sel_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !route_valid |-> (route_sel == 3'b000));

   assert_strobe_after_eof_R8: assert property (@(posedge clk) disable iff (!rst_n)
      route_valid |-> $past(in_valid && in_eof));

   assert_eof_gives_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_eof && (in_sof || frame_open)) |=> route_valid);

   assert_stray_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_eof && !in_sof && !frame_open) |=> !route_valid);

   assert_ip_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(route_valid && route_sel == 3'b010) |-> $stable(ip_addr));
endmodule

bind frame_route_classifier frc_checker u_frc_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_sof      (in_sof),
   .in_eof      (in_eof),
   .frame_open  (frame_open_w),
   .route_valid (route_valid),
   .route_sel   (route_sel),
   .ip_addr     (ip_addr)
);

// File: tb/frame_route_classifier_tb.sv
module frame_route_classifier_tb_top;

   typedef struct packed {
      logic [7:0]  nwords;
      logic [15:0] port;
      logic [31:0] hdr;
      logic [15:0] etype;
      logic [31:0] code;
      logic [31:0] ip;
      logic [2:0]  route;
      logic [11:0] len;
   } vec_t;

   localparam logic [2:0] FAST = 3'b001;
   localparam logic [2:0] REC  = 3'b010;
   localparam logic [2:0] SLOW = 3'b100;
   localparam logic [31:0] ADDR = 32'h61646472;
   localparam logic [31:0] JUNK = 32'h5A5A5A5A;

   localparam int NVEC = 9;
   localparam vec_t VECS [NVEC] = '{
      '{8'd20, 16'h1234, 32'h0000_0005, 16'h0800, JUNK, 32'h0,        FAST, 12'd0 },  // R2
      '{8'd20, 16'h1234, 32'h0000_0000, 16'h0800, JUNK, 32'h0,        SLOW, 12'd16},  // R3
      '{8'd20, 16'h4321, 32'h0000_0005, 16'h0800, JUNK, 32'h0,        SLOW, 12'd16},  // R7
      '{8'd8,  16'h1234, 32'h0000_0005, 16'hBEEE, ADDR, 32'hC0A80A02, REC,  12'd0 },  // R4 (too short for R2)
      '{8'd20, 16'h1234, 32'h0000_0005, 16'hBEEE, ADDR, 32'h0A000001, FAST, 12'd0 },  // R5
      '{8'd11, 16'h1234, 32'h0000_0005, 16'h0800, JUNK, 32'h0,        SLOW, 12'd7 },  // R6
      '{8'd8,  16'h1234, 32'h0000_0005, 16'hBEEE, JUNK, 32'h0,        SLOW, 12'd4 },  // R4 negative
      '{8'd5,  16'h1234, 32'h0000_0005, 16'hBEEE, ADDR, 32'h0,        SLOW, 12'd1 },  // R4 needs word 5
      '{8'd2,  16'h1234, 32'h0000_0005, 16'h0800, JUNK, 32'h0,        SLOW, 12'd0 }   // R7 clamp
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
   logic [31:0] in_word = '0;
   logic [15:0] cfg_data_port = 16'h1234;
   logic [31:0] cfg_bad_hdr = 32'h0;
   logic        route_valid;
   logic [2:0]  route_sel;
   logic [31:0] ip_addr;
   logic [11:0] slow_len;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;
   logic [31:0] exp_ip = 32'h0;

   always #2 clk = ~clk;

   frame_route_classifier dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
      .in_word(in_word), .cfg_data_port(cfg_data_port), .cfg_bad_hdr(cfg_bad_hdr),
      .route_valid(route_valid), .route_sel(route_sel), .ip_addr(ip_addr), .slow_len(slow_len)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   function automatic logic [31:0] word_at(input int i, input vec_t v);
      case (i)
         3:       return {16'hA503, v.etype};
         4:       return v.code;
         5:       return v.ip;
         9:       return {16'hA509, v.port};
         11:      return v.hdr;
         default: return 32'hA500_0000 | i;
      endcase
   endfunction

   function automatic string tag_of(input logic [2:0] r);
      if (r == FAST) return "R2";
      if (r == REC)  return "R4";
      return "R7";
   endfunction

   task automatic send_frame(input vec_t v);
      for (int i = 0; i < int'(v.nwords); i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_sof   = (i == 0);
         in_eof   = (i == int'(v.nwords) - 1);
         in_word  = word_at(i, v);
      end
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
   endtask

   task automatic check_decision(input vec_t v);
      check(route_valid == 1'b1, "R8", 32'(route_valid), 32'd1);
      check(route_sel == v.route, tag_of(v.route), 32'(route_sel), 32'(v.route));
      if (v.route == SLOW)
         check(slow_len == v.len, "R7", 32'(slow_len), 32'(v.len));
      if (v.route == REC) exp_ip = v.ip;
      check(ip_addr == exp_ip, "R9", ip_addr, exp_ip);
      @(negedge clk);
      check(route_valid == 1'b0, "R8", 32'(route_valid), 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      vec_t v;
      repeat (3) @(negedge clk);
      // R1: reset values
      check(route_valid == 1'b0 && route_sel == 3'b000, "R1", {route_valid, route_sel}, 32'h0);
      check(ip_addr == 32'h0 && slow_len == 12'd0, "R1", ip_addr ^ 32'(slow_len), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(route_valid == 1'b0 && ip_addr == 32'h0, "R1", ip_addr, 32'h0);

      // table walk
      for (int k = 0; k < NVEC; k++) begin
         send_frame(VECS[k]);
         check_decision(VECS[k]);
      end

      // R10: stray words outside a frame, one carrying eof
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_sof = 1'b0; in_eof = (i == 2); in_word = 32'hA500_0000;
         if (i > 0) check(route_valid == 1'b0, "R10", 32'(route_valid), 32'd0);
      end
      @(negedge clk);
      in_valid = 1'b0; in_eof = 1'b0;
      check(route_valid == 1'b0, "R10", 32'(route_valid), 32'd0);
      @(negedge clk);
      check(route_valid == 1'b0, "R10", 32'(route_valid), 32'd0);

      // R11: open frame abandoned by a new sof, restart at word 0
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_sof = (i == 0); in_eof = 1'b0; in_word = 32'h1111_0000 | i;
      end
      v = '{8'd8, 16'h0, 32'h5, 16'hBEEE, ADDR, 32'hAC10_0203, REC, 12'd0};
      send_frame(v);
      check(route_sel == REC, "R11", 32'(route_sel), 32'(REC));
      check(ip_addr == 32'hAC10_0203, "R11", ip_addr, 32'hAC10_0203);
      exp_ip = 32'hAC10_0203;
      @(negedge clk);
      check(route_valid == 1'b0, "R11", 32'(route_valid), 32'd0);

      // R8: back-to-back one-word frames
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b1; in_word = 32'h0;
      @(negedge clk);
      check(route_valid == 1'b1 && route_sel == SLOW, "R8", 32'(route_sel), 32'(SLOW));
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      check(route_valid == 1'b1 && slow_len == 12'd0, "R8", 32'(slow_len), 32'd0);
      @(negedge clk);
      check(route_valid == 1'b0, "R8", 32'(route_valid), 32'd0);

      // R3: changed invalid-header value
      cfg_bad_hdr = 32'h0000_0777;
      v = '{8'd14, 16'h1234, 32'h0000_0777, 16'h0800, JUNK, 32'h0, SLOW, 12'd10};
      send_frame(v);
      check(route_sel == SLOW, "R3", 32'(route_sel), 32'(SLOW));
      check(slow_len == 12'd10, "R7", 32'(slow_len), 32'd10);
      @(negedge clk);
      v.hdr = 32'h0; v.route = FAST;
      send_frame(v);
      check(route_sel == FAST, "R2", 32'(route_sel), 32'(FAST));
      check(ip_addr == exp_ip, "R9", ip_addr, exp_ip);
      @(negedge clk);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule